// File: doc/BRIEF.md
# Multi-Rate Lane Deserializer

This block gathers serial data from groups of front-end lanes and packs it into fixed bit fields of a 40 MHz frame. All logic runs on one fast shift clock that gives eight ticks per frame. A strobe input, `frame_stb`, marks the first tick of each frame. Each lane group runs at its own rate. At the 80 Mb/s rate a lane delivers two bits per frame. At 160 Mb/s it delivers four bits, and at 320 Mb/s it delivers eight bits. A group can also be switched off. Each lane always lands in the same bits of the frame, so the position of a field identifies which front end sent it.

The serial bits arrive already phase aligned. The shift clock is offset by half a period from the frame clock, and the block does not know where user words begin or end. Because of this, each captured parallel word holds the last bit of the previous frame followed by the first bits of the current frame. A per-group valid flag stays low while a group is off, after reset, and for the frame that follows a rate change.

Top module: `elink_deser`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `frame_out` and `grp_valid` are all zero.
- R2: The rate code for group g is `rate_sel[2g+1:2g]`: 0 means off, 1 means 2 bits per frame, 2 means 4 bits, 3 means 8 bits. At code 1, every lane l of group g (input `ser_in[8g+l]`) fills `frame_out[16g+2l +: 2]`.
- R3: At code 2, only the even lanes 2k of a group are used. Lane 2k fills `frame_out[16g+4k +: 4]`.
- R4: At code 3, only lanes 4k of a group are used. Lane 4k fills `frame_out[16g+8k +: 8]`.
- R5: Take a group that delivers N bits per frame, so one sample is taken every S = 8/N ticks. Ticks are counted from 0 on the `frame_stb` cycle. Samples are taken on ticks 0, S, 2S, and so on; the sample on tick 0 is cur[N-1] and the last one is cur[0]. On tick 8-S, the captured word {prev[0], cur[N-1:1]} appears, with prev[0] as its MSB.
- R6: Each group follows its own rate code, independently of the other groups.
- R7: A clock edge that samples `frame_stb` high with a group's code at 0 clears that group's field and valid flag. Both stay zero while the group is off.
- R8: A clock edge that samples `frame_stb` high with a group's code different from the code latched at the previous strobe drops that group's valid flag. The flag stays low through the next capture and rises again only at the capture after that.
- R9: A group's field and valid flag change only on that group's capture tick, or on a strobe edge that switches the group off or changes its rate.
- R10: The rate code is latched only on `frame_stb` cycles. Its value on other cycles has no effect on the outputs.
- R11: Lanes not used at the current rate have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, eight ticks per frame |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | High on the first tick of each frame |
| rate_sel | input | 2*N_GROUPS | Per-group rate code (0 off, 1 x2, 2 x4, 3 x8) |
| ser_in | input | N_GROUPS*LANES | Serial lane inputs, lane l of group g at bit g*LANES+l |
| frame_out | output | N_GROUPS*16 | Packed parallel frame, group g at bits 16g upward |
| grp_valid | output | N_GROUPS | Per-group valid flag for the current field |

## Verification
The assertions check four things on every cycle, using their own tick counter and their own copy of the latched rates:
- A group that is switched off clears at once.
- A rate change drops the valid flag.
- The valid flag is never high for a group that is off.
- Each field holds steady except on its own capture tick.

Only the bench scenarios can show the contents of the captured words. These include the straddled bit order, the lane-to-field mapping at each rate, and the fact that unused lanes and mid-frame rate noise are ignored. The bench checks them against a queue-based model of every lane's sample history.

// File: rtl/elink_deser_pkg.sv
package elink_deser_pkg;
  localparam int FRAME_TICKS = 8;
  localparam int TICK_W      = $clog2(FRAME_TICKS);
  localparam int MAX_BITS    = FRAME_TICKS;
  localparam int MIN_BITS    = 2;

  typedef enum logic [1:0] {
    RATE_OFF = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_X8  = 2'd3
  } rate_e;

  // sampling pattern for one rate: tick mask selecting sample slots, and the capture tick
  typedef struct packed {
    logic [TICK_W-1:0] mask;
    logic [TICK_W-1:0] cap_tick;
  } slot_t;

  function automatic slot_t slot_of(rate_e r);
    slot_t s;
    case (r)
      RATE_X2: begin s.mask = TICK_W'(3); s.cap_tick = TICK_W'(FRAME_TICKS - 4); end
      RATE_X4: begin s.mask = TICK_W'(1); s.cap_tick = TICK_W'(FRAME_TICKS - 2); end
      default: begin s.mask = TICK_W'(0); s.cap_tick = TICK_W'(FRAME_TICKS - 1); end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/elink_frame_phase.sv
module elink_frame_phase
  import elink_deser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  output logic [TICK_W-1:0] tick
);
  logic [TICK_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst)            ph_q <= '0;
    else if (frame_stb) ph_q <= TICK_W'(1);
    else                ph_q <= ph_q + TICK_W'(1);
  end

  assign tick = frame_stb ? '0 : ph_q;
endmodule

// File: rtl/elink_lane_shift.sv
module elink_lane_shift
  import elink_deser_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                shift_en,
  input  logic                din,
  output logic [MAX_BITS-1:0] sreg
);
  always_ff @(posedge clk) begin
    if (rst || clr)    sreg <= '0;
    else if (shift_en) sreg <= {sreg[MAX_BITS-2:0], din};
  end
endmodule

// File: rtl/elink_group.sv
module elink_group
  import elink_deser_pkg::*;
#(
  parameter int LANES = 8,
  localparam int GW   = LANES * MIN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [TICK_W-1:0] tick,
  input  logic [1:0]        rate_in,
  input  logic [LANES-1:0]  ser,
  output logic [GW-1:0]     field,
  output logic              valid
);
  rate_e rate_q, rate_nxt;
  slot_t slot;
  logic  off, changed, sample, capture, fresh;
  logic [MAX_BITS-1:0] sr [LANES];
  logic [GW-1:0] packed_w;

  assign rate_nxt = frame_stb ? rate_e'(rate_in) : rate_q;
  assign changed  = frame_stb && (rate_e'(rate_in) != rate_q);
  assign off      = (rate_nxt == RATE_OFF);
  assign slot     = slot_of(rate_nxt);
  assign sample   = !off && ((tick & slot.mask) == '0);
  assign capture  = sample && (tick == slot.cap_tick);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    elink_lane_shift u_shift (
      .clk(clk), .rst(rst), .clr(off), .shift_en(sample), .din(ser[l]), .sreg(sr[l])
    );
  end

  always_comb begin
    packed_w = '0;
    case (rate_nxt)
      RATE_X2: for (int l = 0; l < LANES; l++)     packed_w[2*l +: 2] = sr[l][1:0];
      RATE_X4: for (int k = 0; k < LANES / 2; k++) packed_w[4*k +: 4] = sr[2*k][3:0];
      RATE_X8: for (int k = 0; k < LANES / 4; k++) packed_w[8*k +: 8] = sr[4*k][7:0];
      default: packed_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RATE_OFF;
      field  <= '0;
      valid  <= 1'b0;
      fresh  <= 1'b1;
    end else begin
      rate_q <= rate_nxt;
      if (off) begin
        field <= '0;
        valid <= 1'b0;
        fresh <= 1'b1;
      end else begin
        if (changed) begin
          valid <= 1'b0;
          fresh <= 1'b1;
        end
        if (capture) begin
          field <= packed_w;
          valid <= !fresh && !changed;
          fresh <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/elink_deser.sv
module elink_deser
  import elink_deser_pkg::*;
#(
  parameter int N_GROUPS = 5,
  parameter int LANES    = 8,
  localparam int GW      = LANES * MIN_BITS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_stb,
  input  logic [2*N_GROUPS-1:0]     rate_sel,
  input  logic [N_GROUPS*LANES-1:0] ser_in,
  output logic [N_GROUPS*GW-1:0]    frame_out,
  output logic [N_GROUPS-1:0]       grp_valid
);
  logic [TICK_W-1:0] tick;

  elink_frame_phase u_phase (.clk(clk), .rst(rst), .frame_stb(frame_stb), .tick(tick));

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    elink_group #(.LANES(LANES)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .frame_stb(frame_stb),
      .tick     (tick),
      .rate_in  (rate_sel[2*g +: 2]),
      .ser      (ser_in[g*LANES +: LANES]),
      .field    (frame_out[g*GW +: GW]),
      .valid    (grp_valid[g])
    );
  end
endmodule

// File: rtl/elink_deser_chk.sv
module elink_deser_chk #(
  parameter int N_GROUPS = 5,
  parameter int LANES    = 8,
  localparam int GW      = LANES * 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      frame_stb,
  input logic [2*N_GROUPS-1:0]     rate_sel,
  input logic [N_GROUPS*GW-1:0]    frame_out,
  input logic [N_GROUPS-1:0]       grp_valid
);
  logic [2:0] cph;
  logic [1:0] lr [N_GROUPS];

  function automatic logic [3:0] cap_of(logic [1:0] r);
    case (r)
      2'd1:    return 4'd4;
      2'd2:    return 4'd6;
      2'd3:    return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst)            cph <= '0;
    else if (frame_stb) cph <= 3'd1;
    else                cph <= cph + 3'd1;
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
    always_ff @(posedge clk) begin
      if (rst)            lr[g] <= 2'd0;
      else if (frame_stb) lr[g] <= rate_sel[2*g +: 2];
    end

    p_off_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (frame_stb && rate_sel[2*g +: 2] == 2'd0) |=> (frame_out[g*GW +: GW] == '0 && !grp_valid[g]));

    p_change_drops_valid_r8: assert property (@(posedge clk) disable iff (rst)
      (frame_stb && rate_sel[2*g +: 2] != lr[g]) |=> !grp_valid[g]);

    p_valid_needs_rate_r10: assert property (@(posedge clk) disable iff (rst)
      grp_valid[g] |-> (lr[g] != 2'd0));

    p_hold_between_captures_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(frame_stb) && ({1'b0, $past(cph)} != cap_of(lr[g])))
        |-> ($stable(frame_out[g*GW +: GW]) && $stable(grp_valid[g])));
  end
endmodule

bind elink_deser elink_deser_chk #(.N_GROUPS(N_GROUPS), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .rate_sel(rate_sel),
  .frame_out(frame_out), .grp_valid(grp_valid)
);

// File: tb/elink_deser_test.sv
module elink_deser_test;
  localparam int PERIOD = 10;
  localparam int NG = 5;
  localparam int LN = 8;
  localparam int GW = LN * 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic [2*NG-1:0]  rate_sel = '0;
  logic [NG*LN-1:0] ser_in = '0;
  logic [NG*GW-1:0] frame_out;
  logic [NG-1:0]    grp_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // behavioural model state
  int        ract  [NG];
  bit        fresh [NG];
  bit [GW-1:0] ef  [NG];
  bit        ev    [NG];
  int        mph;
  bit        hist [NG*LN][$];

  always #(PERIOD/2) clk = ~clk;

  elink_deser #(.N_GROUPS(NG), .LANES(LN)) uut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rate_sel(rate_sel),
    .ser_in(ser_in), .frame_out(frame_out), .grp_valid(grp_valid)
  );

  function automatic int lastn(int lane, int n);
    int v = 0;
    for (int i = 0; i < n; i++) begin
      int idx = hist[lane].size() - n + i;
      v = (v << 1) | ((idx >= 0) ? int'(hist[lane][idx]) : 0);
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int g = 0; g < NG; g++) begin
      ract[g] = 0; fresh[g] = 1'b1; ef[g] = '0; ev[g] = 1'b0;
    end
    for (int l = 0; l < NG*LN; l++) hist[l].delete();
    mph = 0;
  endtask

  task automatic model_step(input bit stb, input logic [2*NG-1:0] rs, input logic [NG*LN-1:0] din);
    int tk = stb ? 0 : mph;
    for (int g = 0; g < NG; g++) begin
      int rn = stb ? int'(rs[2*g +: 2]) : ract[g];
      if (rn == 0) begin
        ef[g] = '0; ev[g] = 1'b0; fresh[g] = 1'b1;
        for (int l = 0; l < LN; l++) hist[g*LN+l].delete();
      end else begin
        int nb = 1 << rn;
        int st = 8 / nb;
        bit chg = stb && (rn != ract[g]);
        if (chg) begin ev[g] = 1'b0; fresh[g] = 1'b1; end
        if (tk % st == 0) begin
          if (tk == 8 - st) begin
            bit [GW-1:0] f = '0;
            for (int k = 0; k < LN / (nb/2); k++) begin
              int w = lastn(g*LN + k*(nb/2), nb);
              for (int b = 0; b < nb; b++) f[k*nb + b] = w[b];
            end
            ef[g] = f;
            ev[g] = !fresh[g] && !chg;
            fresh[g] = 1'b0;
          end
          for (int l = 0; l < LN; l++) begin
            hist[g*LN+l].push_back(din[g*LN+l]);
            if (hist[g*LN+l].size() > 8) void'(hist[g*LN+l].pop_front());
          end
        end
      end
      ract[g] = rn;
    end
    mph = (tk + 1) % 8;
  endtask

  task automatic compare(input string tag);
    for (int g = 0; g < NG; g++) begin
      checks++;
      if (frame_out[g*GW +: GW] !== ef[g] || grp_valid[g] !== ev[g]) begin
        fails++;
        $display("FAIL %s R9 cycle %0d group %0d: field %h valid %b, expected field %h valid %b",
                 tag, cyc, g, frame_out[g*GW +: GW], grp_valid[g], ef[g], ev[g]);
      end
    end
  endtask

  task automatic cycle(input string tag, input logic [2*NG-1:0] rs, input bit noise, input int l0);
    logic [63:0] r64;
    logic [NG*LN-1:0] din;
    bit stb;
    @(negedge clk);
    compare(tag);
    stb = (cyc % 8 == 0);
    r64 = {$urandom(), $urandom()};
    din = r64[NG*LN-1:0];
    if (l0 >= 0) din[0] = l0[0];
    frame_stb = stb;
    ser_in = din;
    r64 = {$urandom(), $urandom()};
    rate_sel = (noise && !stb) ? r64[2*NG-1:0] : rs;
    model_step(stb, rate_sel, din);
    cyc++;
  endtask

  task automatic run(input string tag, input logic [2*NG-1:0] rs, input int n, input bit noise);
    for (int i = 0; i < n; i++) cycle(tag, rs, noise, -1);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (frame_out !== '0 || grp_valid !== '0) begin
      fails++;
      $display("FAIL R1 reset: field %h valid %b, expected 0 and 0", frame_out, grp_valid);
    end
    @(negedge clk);
    rst = 1'b0;
    run("R1", '0, 8, 1'b0);

    run("R2 R5", {NG{2'd1}}, 64, 1'b0);
    run("R3 R5 R11", {NG{2'd2}}, 64, 1'b0);
    run("R4 R5 R11", {NG{2'd3}}, 64, 1'b0);

    // directed straddle order on group 0 lane 0 at x8
    pat = 16'b0000_0001_1011_0010;
    for (int k = 0; k < 16; k++) cycle("R4 R5", {NG{2'd3}}, 1'b0, int'(pat[15-k]));
    @(posedge clk); #1;
    checks++;
    if (frame_out[7:0] !== 8'hD9) begin
      fails++;
      $display("FAIL R5 straddled word: got %h expected d9", frame_out[7:0]);
    end

    run("R6", {2'd1, 2'd2, 2'd0, 2'd1, 2'd3}, 64, 1'b0);
    run("R7", {2'd0, 2'd2, 2'd0, 2'd0, 2'd3}, 32, 1'b0);
    @(posedge clk); #1;
    checks++;
    if (frame_out[GW +: GW] !== '0 || grp_valid[1] !== 1'b0) begin
      fails++;
      $display("FAIL R7 off group: field %h valid %b expected 0 0", frame_out[GW +: GW], grp_valid[1]);
    end

    for (int j = 0; j < 10; j++) begin
      logic [31:0] r = $urandom();
      run("R8", r[2*NG-1:0], 16, 1'b0);
    end
    run("R8", {NG{2'd2}}, 16, 1'b0);
    run("R8", {NG{2'd1}}, 3, 1'b0);
    @(posedge clk); #1;
    checks++;
    if (grp_valid !== '0) begin
      fails++;
      $display("FAIL R8 after change: valid %b expected 00000", grp_valid);
    end

    run("R10", {2'd3, 2'd2, 2'd1, 2'd3, 2'd2}, 96, 1'b1);
    run("R10 R11", {NG{2'd2}}, 64, 1'b1);

    @(negedge clk);
    compare("final");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule